// File: doc/BRIEF.md
# Message-signalled interrupt capability with vector dispatch

This block holds the message-signalled interrupt capability of one PCI function and turns per-vector interrupt requests into outbound memory-write messages. Configuration software reaches the capability through a dword-addressed register window. Writes carry byte enables. Reads return the addressed dword at once. The window holds a control word, the message address (one or two dwords), the message data, and, when per-vector masking is built in, a mask register and a read-only pending register.

A device raises an interrupt by pulsing `irq_req` with a vector number. While the capability is enabled, an unmasked request in range becomes one message. The message carries the programmed address, the data word with its low bits replaced by the vector number, and a requester stream ID built from the bus and device/function numbers. A masked request only records the vector as pending. When a later configuration write leaves a pending vector unmasked, that vector is replayed, lowest vector first.

Messages leave through a valid/ready handshake. While any message is queued or in flight, the block holds `cfg_wr_ready` low and ignores configuration writes. Parameters choose 64-bit addressing, per-vector masking, the supported vector count (as log2) and the capability's byte offset.

Top module: `msi_cap_unit`

## Requirements
- R1: After reset, the enable bit, the enabled-count field, both address dwords, the data word, the mask and the pending register read zero. Dword 0 of the capability reads with the capability ID 0x05 in bits 7:0 and the next pointer in bits 15:8. Its upper half holds the enable bit in bit 16, the supported-count log2 in bits 19:17, the enabled-count log2 in bits 22:20, the 64-bit option in bit 23 and the masking option in bit 24. With the default parameters it reads 0x0186_0005.
- R2: Only bits 16 and 22:20 of dword 0 take writes. Bits 1:0 of the low address dword (dword 1) always read zero. The high address dword (dword 2, 64-bit mode) takes all 32 bits. In the data dword (dword 3 in 64-bit mode, else dword 2) only bits 15:0 are writable, and bits 31:16 read zero. Writes honour the byte enables.
- R3: In the mask dword (after the data dword), only bits 0 to N-1 are writable, where N is the supported vector count. The pending dword that follows it ignores writes.
- R4: While enabled, an unmasked in-range request on the edge of cycle t sets `msg_valid` from edge t+1. The address is {high dword, low dword} in 64-bit mode and the zero-extended low dword in 32-bit mode. `msg_sid` is {bus_num, devfn}.
- R5: `msg_data` bits 31:16 are zero. With the enabled-count log2 E = 0 it equals the data word. For E > 0, its low E bits are replaced by the vector number.
- R6: A request on a masked vector sets that vector's pending bit and sends no message. Without masking, no vector counts as masked.
- R7: A configuration write that touches a byte of the capability while the enable bit (after the write) is set does three things. It pulses `intx_deassert` high for one cycle. It lowers an enabled-count field above the supported value to the supported value. It clears pending bits at or above the (clamped) enabled count.
- R8: After such a write, every pending and unmasked vector has its pending bit cleared and is sent in ascending vector order.
- R9: Each message stays valid with stable address and data until `msg_ready` is seen, and the next queued vector follows. `cfg_wr_ready` is low while any message is queued or valid, and a write then has no effect.
- R10: A request while the enable bit is clear is dropped. A request while enabled with a vector at or above the enabled count is dropped and pulses `vec_err` for one cycle, one edge later.
- R11: A write that touches no byte of the capability does not pulse `intx_deassert`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Dword index into configuration space (read and write) |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr, zero outside the capability |
| cfg_wr_ready | output | 1 | High when a write will be taken |
| irq_req | input | 1 | Interrupt request strobe |
| irq_vec | input | 5 | Vector number of the request |
| bus_num | input | 8 | Bus number for the stream ID |
| devfn | input | 8 | Device/function number for the stream ID |
| msg_valid | output | 1 | Outbound message valid |
| msg_ready | input | 1 | Outbound message accepted |
| msg_addr | output | 64 | Message write address |
| msg_data | output | 32 | Message write data, byte 0 in bits 7:0 |
| msg_sid | output | 16 | Requester stream ID |
| intx_deassert | output | 1 | One-cycle strobe to drop legacy interrupts |
| vec_err | output | 1 | One-cycle strobe for an out-of-range vector |

## Verification
The dispatch path is tried with single unmasked requests under different enabled counts. This shows whether the vector number lands in the right low data bits or leaves the data word untouched. Masked requests followed by an unmasking write, with `msg_ready` held low for a while, check that pending vectors replay lowest-first and that a stalled message keeps its contents while writes are refused. Writes that over-program the enabled count, that shrink it with pending bits above the new limit, that fall outside the capability, or that disable it, check the clamp, the trimming and the absence of spurious strobes.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

    localparam int          MAX_VEC    = 32;
    localparam logic [7:0]  CAP_ID_MSI = 8'h05;

    // Bitmap of vectors below the enabled count 2**lg
    function automatic logic [MAX_VEC-1:0] vec_below(input logic [2:0] lg);
        logic [MAX_VEC-1:0] r;
        if (lg >= 3'd5) begin
            r = '1;
        end else begin
            r = (32'd1 << (32'd1 << lg)) - 32'd1;
        end
        return r;
    endfunction

    // Index of the lowest set bit (0 when none)
    function automatic logic [4:0] lowest_set(input logic [MAX_VEC-1:0] v);
        logic [4:0] r;
        r = '0;
        for (int i = MAX_VEC - 1; i >= 0; i--) begin
            if (v[i]) begin
                r = 5'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
    import msi_cap_pkg::*;
#(
    parameter bit          ADDR64   = 1'b1,
    parameter bit          MASK_EN  = 1'b1,
    parameter int unsigned VEC_LOG2 = 3,
    parameter logic [7:0]  CAP_BASE = 8'h50,
    parameter logic [7:0]  NEXT_PTR = 8'h00
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_fire,
    input  logic [5:0]         addr,
    input  logic [3:0]         be,
    input  logic [31:0]        wdata,
    input  logic [MAX_VEC-1:0] pend_set,
    output logic [31:0]        rdata,
    output logic               en_o,
    output logic [2:0]         mme_o,
    output logic [MAX_VEC-1:0] mask_o,
    output logic [63:0]        addr_o,
    output logic [15:0]        data_o,
    output logic [MAX_VEC-1:0] replay_o,
    output logic               intx_o
);

    localparam logic [5:0] BASE_DW = CAP_BASE[7:2];
    localparam int  CAP_LEN = (ADDR64 ? 14 : 10) + (MASK_EN ? 10 : 0);
    localparam int  CAP_END = int'(CAP_BASE) + CAP_LEN;
    localparam int  NUM_DW  = (CAP_LEN + 3) / 4;
    localparam logic [5:0] DW_DATA = ADDR64 ? 6'd3 : 6'd2;
    localparam logic [5:0] DW_MASK = DW_DATA + 6'd1;
    localparam logic [5:0] DW_PEND = DW_DATA + 6'd2;
    localparam logic [MAX_VEC-1:0] VEC_MASK = vec_below(3'(VEC_LOG2));
    localparam logic [31:0] CTL_WMASK = 32'h0071_0000;

    typedef struct packed {
        logic               en;
        logic [2:0]         mme;
        logic [31:0]        addr_lo;
        logic [31:0]        addr_hi;
        logic [15:0]        data;
        logic [MAX_VEC-1:0] mask;
        logic [MAX_VEC-1:0] pend;
        logic               intx;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    logic [5:0]         rel;
    logic               in_win;
    logic [31:0]        wm;
    logic [31:0]        bm;
    logic [31:0]        nw;
    logic               overlap;
    logic [MAX_VEC-1:0] replay;

    assign rel    = addr - BASE_DW;
    assign in_win = (addr >= BASE_DW) && (int'(rel) < NUM_DW);

    // Read view of the addressed dword
    always_comb begin
        rdata = '0;
        if (in_win) begin
            if (rel == 6'd0) begin
                rdata = {7'b0, MASK_EN, ADDR64, st_q.mme, 3'(VEC_LOG2),
                         st_q.en, NEXT_PTR, CAP_ID_MSI};
            end else if (rel == 6'd1) begin
                rdata = st_q.addr_lo;
            end else if (ADDR64 && rel == 6'd2) begin
                rdata = st_q.addr_hi;
            end else if (rel == DW_DATA) begin
                rdata = {16'b0, st_q.data};
            end else if (MASK_EN && rel == DW_MASK) begin
                rdata = st_q.mask;
            end else if (MASK_EN && rel == DW_PEND) begin
                rdata = st_q.pend;
            end
        end
    end

    // Writable bits of the addressed dword
    always_comb begin
        wm = '0;
        if (in_win) begin
            if (rel == 6'd0) begin
                wm = CTL_WMASK;
            end else if (rel == 6'd1) begin
                wm = 32'hFFFF_FFFC;
            end else if (ADDR64 && rel == 6'd2) begin
                wm = 32'hFFFF_FFFF;
            end else if (rel == DW_DATA) begin
                wm = 32'h0000_FFFF;
            end else if (MASK_EN && rel == DW_MASK) begin
                wm = VEC_MASK;
            end
        end
    end

    always_comb begin
        bm = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
        nw = (rdata & ~(wm & bm)) | (wdata & wm & bm);
        overlap = 1'b0;
        for (int b = 0; b < 4; b++) begin
            if (be[b] && (int'({addr, 2'(b)}) >= int'(CAP_BASE))
                      && (int'({addr, 2'(b)}) < CAP_END)) begin
                overlap = 1'b1;
            end
        end
    end

    // Next state
    always_comb begin
        st_d      = st_q;
        st_d.intx = 1'b0;
        replay    = '0;
        if (wr_fire) begin
            if (in_win) begin
                if (rel == 6'd0) begin
                    st_d.en  = nw[16];
                    st_d.mme = nw[22:20];
                end else if (rel == 6'd1) begin
                    st_d.addr_lo = nw;
                end else if (ADDR64 && rel == 6'd2) begin
                    st_d.addr_hi = nw;
                end else if (rel == DW_DATA) begin
                    st_d.data = nw[15:0];
                end else if (MASK_EN && rel == DW_MASK) begin
                    st_d.mask = nw;
                end
            end
            if (overlap && st_d.en) begin
                st_d.intx = 1'b1;
                if (st_d.mme > 3'(VEC_LOG2)) begin
                    st_d.mme = 3'(VEC_LOG2);
                end
                if (MASK_EN) begin
                    st_d.pend = st_d.pend & vec_below(st_d.mme);
                    replay    = st_d.pend & ~st_d.mask;
                    st_d.pend = st_d.pend & ~replay;
                end
            end
        end
        if (MASK_EN) begin
            st_d.pend = st_d.pend | pend_set;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o     = st_q.en;
    assign mme_o    = st_q.mme;
    assign mask_o   = st_q.mask;
    assign addr_o   = ADDR64 ? {st_q.addr_hi, st_q.addr_lo} : {32'b0, st_q.addr_lo};
    assign data_o   = st_q.data;
    assign replay_o = replay;
    assign intx_o   = st_q.intx;

endmodule

// File: rtl/msi_send_queue.sv
module msi_send_queue
    import msi_cap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [MAX_VEC-1:0] set_i,
    input  logic               ready_i,
    output logic               valid_o,
    output logic [4:0]         vec_o,
    output logic               busy_o
);

    typedef struct packed {
        logic [MAX_VEC-1:0] waiting;
        logic               valid;
        logic [4:0]         vec;
    } q_state_t;

    q_state_t q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (!q_q.valid || ready_i) begin
            if (|q_q.waiting) begin
                q_d.valid              = 1'b1;
                q_d.vec                = lowest_set(q_q.waiting);
                q_d.waiting[q_d.vec]   = 1'b0;
            end else begin
                q_d.valid = 1'b0;
            end
        end
        q_d.waiting = q_d.waiting | set_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign valid_o = q_q.valid;
    assign vec_o   = q_q.vec;
    assign busy_o  = (|q_q.waiting) || q_q.valid;

endmodule

// File: rtl/msi_msg_format.sv
module msi_msg_format (
    input  logic [63:0] base_addr,
    input  logic [15:0] base_data,
    input  logic [2:0]  mme,
    input  logic [4:0]  vec,
    input  logic [7:0]  bus_num,
    input  logic [7:0]  devfn,
    output logic [63:0] addr_o,
    output logic [31:0] data_o,
    output logic [15:0] sid_o
);

    logic [15:0] keep;

    always_comb begin
        keep   = 16'hFFFF << mme;
        addr_o = base_addr;
        if (mme == 3'd0) begin
            data_o = {16'b0, base_data};
        end else begin
            data_o = {16'b0, (base_data & keep) | ({11'b0, vec} & ~keep)};
        end
        sid_o  = {bus_num, devfn};
    end

endmodule

// File: rtl/msi_cap_unit.sv
module msi_cap_unit
    import msi_cap_pkg::*;
#(
    parameter bit          ADDR64   = 1'b1,
    parameter bit          MASK_EN  = 1'b1,
    parameter int unsigned VEC_LOG2 = 3,
    parameter logic [7:0]  CAP_BASE = 8'h50,
    parameter logic [7:0]  NEXT_PTR = 8'h00
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [5:0]  cfg_addr,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        cfg_wr_ready,
    input  logic        irq_req,
    input  logic [4:0]  irq_vec,
    input  logic [7:0]  bus_num,
    input  logic [7:0]  devfn,
    output logic        msg_valid,
    input  logic        msg_ready,
    output logic [63:0] msg_addr,
    output logic [31:0] msg_data,
    output logic [15:0] msg_sid,
    output logic        intx_deassert,
    output logic        vec_err
);

    typedef struct packed {
        logic err;
    } top_state_t;

    top_state_t t_d, t_q;

    logic               en;
    logic [2:0]         mme;
    logic [MAX_VEC-1:0] mask;
    logic [63:0]        base_addr;
    logic [15:0]        base_data;
    logic [MAX_VEC-1:0] replay;
    logic [MAX_VEC-1:0] pend_set;
    logic [MAX_VEC-1:0] q_set;
    logic               busy;
    logic               wr_fire;
    logic [4:0]         slot_vec;
    logic               in_range;
    logic               masked;
    logic [MAX_VEC-1:0] vec_1h;

    assign wr_fire = cfg_we && !busy;

    msi_cfg_regs #(
        .ADDR64  (ADDR64),
        .MASK_EN (MASK_EN),
        .VEC_LOG2(VEC_LOG2),
        .CAP_BASE(CAP_BASE),
        .NEXT_PTR(NEXT_PTR)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_fire (wr_fire),
        .addr    (cfg_addr),
        .be      (cfg_be),
        .wdata   (cfg_wdata),
        .pend_set(pend_set),
        .rdata   (cfg_rdata),
        .en_o    (en),
        .mme_o   (mme),
        .mask_o  (mask),
        .addr_o  (base_addr),
        .data_o  (base_data),
        .replay_o(replay),
        .intx_o  (intx_deassert)
    );

    // Request decode against the current register state
    always_comb begin
        vec_1h   = MAX_VEC'(1) << irq_vec;
        in_range = |(vec_below(mme) & vec_1h);
        masked   = MASK_EN && mask[irq_vec];
        pend_set = '0;
        q_set    = replay;
        t_d.err  = 1'b0;
        if (irq_req && en) begin
            if (!in_range) begin
                t_d.err = 1'b1;
            end else if (masked) begin
                pend_set = vec_1h;
            end else begin
                q_set = q_set | vec_1h;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    msi_send_queue u_queue (
        .clk    (clk),
        .rst    (rst),
        .set_i  (q_set),
        .ready_i(msg_ready),
        .valid_o(msg_valid),
        .vec_o  (slot_vec),
        .busy_o (busy)
    );

    msi_msg_format u_fmt (
        .base_addr(base_addr),
        .base_data(base_data),
        .mme      (mme),
        .vec      (slot_vec),
        .bus_num  (bus_num),
        .devfn    (devfn),
        .addr_o   (msg_addr),
        .data_o   (msg_data),
        .sid_o    (msg_sid)
    );

    assign cfg_wr_ready = !busy;
    assign vec_err      = t_q.err;

endmodule

// File: rtl/msi_cap_checker.sv
module msi_cap_checker (
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic        cfg_wr_ready,
    input logic        irq_req,
    input logic        msg_valid,
    input logic        msg_ready,
    input logic [63:0] msg_addr,
    input logic [31:0] msg_data,
    input logic        intx_deassert,
    input logic        vec_err
);

    AST_MSG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data))); // R9

    AST_CFG_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> !cfg_wr_ready); // R9

    AST_INTX_CAUSE: assert property (@(posedge clk) disable iff (rst)
        intx_deassert |-> $past(cfg_we && cfg_wr_ready)); // R7

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        vec_err |-> $past(irq_req)); // R10

    AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (msg_addr[1:0] == 2'b00)); // R2

    AST_DATA_UPPER: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (msg_data[31:16] == 16'h0000)); // R5

endmodule

bind msi_cap_unit msi_cap_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .cfg_wr_ready (cfg_wr_ready),
    .irq_req      (irq_req),
    .msg_valid    (msg_valid),
    .msg_ready    (msg_ready),
    .msg_addr     (msg_addr),
    .msg_data     (msg_data),
    .intx_deassert(intx_deassert),
    .vec_err      (vec_err)
);

// File: tb/msi_cap_unit_test.sv
`timescale 1ns/1ps
module msi_cap_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_wr_ready;
    logic        irq_req = 1'b0;
    logic [4:0]  irq_vec = '0;
    logic [7:0]  bus_num = 8'h3C;
    logic [7:0]  devfn = 8'h A1;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;
    logic [15:0] msg_sid;
    logic        intx_deassert;
    logic        vec_err;

    msi_cap_unit uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cfg_wr_ready(cfg_wr_ready), .irq_req(irq_req), .irq_vec(irq_vec),
        .bus_num(bus_num), .devfn(devfn), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data),
        .msg_sid(msg_sid), .intx_deassert(intx_deassert), .vec_err(vec_err)
    );

    always #2.5 clk = ~clk;

    // Dword indices with the default layout (capability at byte 0x50, 64-bit, masking)
    localparam logic [5:0] A_CTL = 6'h14, A_ALO = 6'h15, A_AHI = 6'h16,
                           A_DAT = 6'h17, A_MSK = 6'h18, A_PND = 6'h19;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int got[$];

    // Behavioural reference state
    bit          m_en;
    int          m_mme;
    bit [31:0]   m_alo, m_ahi, m_msk, m_pnd, m_sq;
    bit [15:0]   m_dat;
    bit          m_sv, m_intx, m_err;
    int          m_svec;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit [31:0] merge(input bit [31:0] old, input bit [31:0] nw,
                                        input bit [31:0] wm, input bit [3:0] be);
        bit [31:0] m;
        m = wm & {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
        return (old & ~m) | (nw & m);
    endfunction

    always @(posedge clk) begin
        bit        rdy, ov;
        bit [31:0] pset, qset, rep;
        int        cnt, ba;
        if (rst) begin
            m_en = 0; m_mme = 0; m_alo = 0; m_ahi = 0; m_msk = 0; m_pnd = 0;
            m_sq = 0; m_dat = 0; m_sv = 0; m_intx = 0; m_err = 0; m_svec = 0;
        end else begin
            if (msg_valid && msg_ready) got.push_back(int'(msg_data[2:0]));
            rdy = (m_sq == 0) && !m_sv;
            if (!m_sv || msg_ready) begin
                if (m_sq != 0) begin
                    for (int i = 31; i >= 0; i--) if (m_sq[i]) m_svec = i;
                    m_sv = 1;
                    m_sq[m_svec] = 0;
                end else begin
                    m_sv = 0;
                end
            end
            pset = 0; qset = 0; m_err = 0; m_intx = 0;
            cnt = 1 << m_mme;
            if (irq_req && m_en) begin
                if (int'(irq_vec) < cnt) begin
                    if (m_msk[irq_vec]) pset[irq_vec] = 1;
                    else qset[irq_vec] = 1;
                end else begin
                    m_err = 1;
                end
            end
            if (cfg_we && rdy) begin
                case (cfg_addr)
                    A_CTL: if (cfg_be[2]) begin m_en = cfg_wdata[16]; m_mme = int'(cfg_wdata[22:20]); end
                    A_ALO: m_alo = merge(m_alo, cfg_wdata, 32'hFFFF_FFFC, cfg_be);
                    A_AHI: m_ahi = merge(m_ahi, cfg_wdata, 32'hFFFF_FFFF, cfg_be);
                    A_DAT: m_dat = 16'(merge({16'b0, m_dat}, cfg_wdata, 32'h0000_FFFF, cfg_be));
                    A_MSK: m_msk = merge(m_msk, cfg_wdata, 32'h0000_00FF, cfg_be);
                    default: ;
                endcase
                ov = 0;
                for (int b = 0; b < 4; b++) begin
                    ba = int'(cfg_addr) * 4 + b;
                    if (cfg_be[b] && ba >= 'h50 && ba < 'h68) ov = 1;
                end
                if (ov && m_en) begin
                    m_intx = 1;
                    if (m_mme > 3) m_mme = 3;
                    m_pnd = m_pnd & ((32'd1 << (1 << m_mme)) - 1);
                    rep = m_pnd & ~m_msk;
                    m_pnd = m_pnd & ~rep;
                    m_sq = m_sq | rep;
                end
            end
            m_pnd = m_pnd | pset;
            m_sq = m_sq | qset;
        end
    end

    // Compare against the reference between edges
    always begin
        bit [31:0] ed;
        @(negedge clk);
        #1;
        if (!rst) begin
            chk(msg_valid == m_sv, "R4 msg_valid", 64'(msg_valid), 64'(m_sv));
            if (m_sv) begin
                if (m_mme == 0) ed = {16'b0, m_dat};
                else ed = {16'b0, (m_dat & ~16'((1 << m_mme) - 1)) | 16'(m_svec)};
                chk(msg_addr == {m_ahi, m_alo}, "R4 msg_addr", msg_addr, {m_ahi, m_alo});
                chk(msg_data == ed, "R5 msg_data", 64'(msg_data), 64'(ed));
                chk(msg_sid == {bus_num, devfn}, "R4 msg_sid", 64'(msg_sid), 64'({bus_num, devfn}));
            end
            chk(intx_deassert == m_intx, "R7 intx_deassert", 64'(intx_deassert), 64'(m_intx));
            chk(vec_err == m_err, "R10 vec_err", 64'(vec_err), 64'(m_err));
            chk(cfg_wr_ready == ((m_sq == 0) && !m_sv), "R9 cfg_wr_ready",
                64'(cfg_wr_ready), 64'((m_sq == 0) && !m_sv));
        end
    end

    task automatic cfg_wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
    endtask

    task automatic irq(input int v);
        @(negedge clk);
        irq_req = 1'b1; irq_vec = 5'(v);
        @(negedge clk);
        irq_req = 1'b0;
        #1;
    endtask

    task automatic rd_check(input logic [5:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_addr = a;
        #1;
        chk(cfg_rdata == exp, tag, 64'(cfg_rdata), 64'(exp));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd_check(A_CTL, 32'h0186_0005, "R1 control after reset");
        rd_check(A_ALO, 32'h0, "R1 addr_lo after reset");
        rd_check(A_AHI, 32'h0, "R1 addr_hi after reset");
        rd_check(A_DAT, 32'h0, "R1 data after reset");
        rd_check(A_MSK, 32'h0, "R1 mask after reset");
        rd_check(A_PND, 32'h0, "R1 pending after reset");

        // R2 / R3: write masks
        cfg_wr(A_ALO, 4'hF, 32'hFFFF_FFFF);
        rd_check(A_ALO, 32'hFFFF_FFFC, "R2 addr_lo low bits");
        cfg_wr(A_AHI, 4'hF, 32'h1234_5678);
        rd_check(A_AHI, 32'h1234_5678, "R2 addr_hi");
        cfg_wr(A_DAT, 4'hF, 32'hABCD_5A5B);
        rd_check(A_DAT, 32'h0000_5A5B, "R2 data upper half");
        cfg_wr(A_DAT, 4'h2, 32'h0000_0000);
        rd_check(A_DAT, 32'h0000_005B, "R2 data byte enable");
        cfg_wr(A_DAT, 4'h2, 32'h0000_5A00);
        cfg_wr(A_MSK, 4'hF, 32'hFFFF_FFFF);
        rd_check(A_MSK, 32'h0000_00FF, "R3 mask width");
        cfg_wr(A_PND, 4'hF, 32'h0000_00FF);
        rd_check(A_PND, 32'h0, "R3 pending read-only");
        cfg_wr(A_MSK, 4'hF, 32'h0);

        // R7: enable with over-large count clamps and strobes
        cfg_wr(A_CTL, 4'hF, 32'hFFFF_FFFF);
        chk(intx_deassert == 1'b1, "R7 strobe on enabling write", 64'(intx_deassert), 64'd1);
        rd_check(A_CTL, 32'h01B7_0005, "R7 enabled count clamp");

        // R4 / R5: unmasked request, 8 vectors
        irq(5);
        idle(3);
        chk(got.size() == 1 && got[0] == 5, "R4 single message", 64'(got.size()), 64'd1);

        // R5: one vector leaves data intact; R10 out-of-range
        cfg_wr(A_CTL, 4'h4, 32'h0001_0000);
        irq(0);
        idle(3);
        irq(1);
        chk(vec_err == 1'b1, "R10 out-of-range strobe", 64'(vec_err), 64'd1);
        idle(3);
        chk(got.size() == 2, "R10 out-of-range not sent", 64'(got.size()), 64'd2);

        // R6: masked requests go pending
        cfg_wr(A_CTL, 4'h4, 32'h0031_0000);
        cfg_wr(A_MSK, 4'hF, 32'h0000_0024);
        irq(5);
        irq(2);
        irq(7);
        idle(3);
        rd_check(A_PND, 32'h0000_0024, "R6 pending bits");
        chk(got.size() == 3 && got[2] == 7, "R6 only unmasked sent", 64'(got.size()), 64'd3);

        // R8 / R9: replay in order under backpressure
        got.delete();
        msg_ready = 1'b0;
        cfg_wr(A_MSK, 4'hF, 32'h0);
        idle(4);
        cfg_wr(A_DAT, 4'hF, 32'h0000_1111);
        chk(cfg_wr_ready == 1'b0, "R9 write refused while busy", 64'(cfg_wr_ready), 64'd0);
        @(negedge clk);
        msg_ready = 1'b1;
        idle(5);
        chk(got.size() == 2, "R8 replay count", 64'(got.size()), 64'd2);
        if (got.size() == 2) begin
            chk(got[0] == 2 && got[1] == 5, "R8 ascending order", 64'(got[0]), 64'd2);
        end
        rd_check(A_DAT, 32'h0000_5A5B, "R9 ignored write left data");
        rd_check(A_PND, 32'h0, "R8 pending cleared");

        // R7: shrinking the count trims pending bits
        cfg_wr(A_MSK, 4'hF, 32'h0000_00FF);
        irq(6);
        irq(1);
        rd_check(A_PND, 32'h0000_0042, "R6 two pending");
        cfg_wr(A_CTL, 4'h4, 32'h0011_0000);
        rd_check(A_PND, 32'h0000_0002, "R7 pending trimmed");
        rd_check(A_CTL, 32'h0197_0005, "R7 control after shrink");
        cfg_wr(A_CTL, 4'h4, 32'h0031_0000);
        got.delete();
        cfg_wr(A_MSK, 4'hF, 32'h0);
        idle(4);
        chk(got.size() == 1 && got[0] == 1, "R8 replay of survivor", 64'(got.size()), 64'd1);

        // R11: write outside the capability
        cfg_wr(6'h1A, 4'hF, 32'hFFFF_FFFF);
        chk(intx_deassert == 1'b0, "R11 no strobe outside", 64'(intx_deassert), 64'd0);
        cfg_wr(6'h13, 4'hF, 32'hFFFF_FFFF);
        chk(intx_deassert == 1'b0, "R11 no strobe below", 64'(intx_deassert), 64'd0);

        // R10: disabled requests dropped
        cfg_wr(A_CTL, 4'h4, 32'h0030_0000);
        chk(intx_deassert == 1'b0, "R7 no strobe when disabling", 64'(intx_deassert), 64'd0);
        got.delete();
        irq(3);
        idle(3);
        chk(got.size() == 0 && msg_valid == 1'b0, "R10 disabled request dropped", 64'(got.size()), 64'd0);
        rd_check(A_PND, 32'h0, "R10 nothing pending");

        // R1: reset again restores zeros
        @(negedge clk);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        rd_check(A_CTL, 32'h0186_0005, "R1 control after second reset");
        rd_check(A_AHI, 32'h0, "R1 addr_hi after second reset");

        idle(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule